// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a small 32-bit processor that completes one instruction on every rising clock edge. In one combinational pass it reads the instruction word at the program counter, decodes it, reads two source registers, computes a result in the ALU, optionally reads or writes one data word, and presents the value to be written back. It covers a reduced RV32I subset:
- register-register ADD, SUB, AND, OR, XOR, SLL, SRL, SRA
- immediate ADDI, ANDI, ORI, XORI, SLLI, SRLI, SRAI
- full-word LW and SW
- conditional branches BEQ, BNE, BLT, BGE
- JAL

Conditional branches are not resolved by a separate comparator. The ALU subtracts the two operands and reports four flags: zero, negative, signed overflow and carry. The branch condition is taken from these flags.

The instruction store and the data store are separate word arrays inside the block. The instruction store is filled through a valid/ready load stream while reset is held. The load port asserts ready only during reset, so a word offered while the core runs is left pending and never written. Each cycle out of reset the block drives a retire trace with the PC, the instruction, and any register or memory write. This trace has no back-pressure: a consumer must take one entry per clock.

Top module: `rv_core`

## Requirements
- R1: Out of reset, exactly one instruction retires per clock. `ret_valid` is high, and when the retired instruction is neither a branch nor JAL, the next `ret_pc` is the current one plus 4.
- R2: While `rst` (synchronous, active high) is high, `ret_valid`, `rf_we` and `dm_we` are low. The first instruction retired after reset is at address 0x00000000.
- R3: Register-register operations use opcode 0110011. The operation is selected by funct7/funct3:
  - 0000000/000 ADD, 0100000/000 SUB
  - 0000000/001 SLL, 0000000/101 SRL, 0100000/101 SRA
  - 0000000/100 XOR, 0000000/110 OR, 0000000/111 AND
  - Shift amounts come from rs2 bits [4:0].
- R4: Immediate operations use opcode 0010011 with a sign-extended 12-bit immediate in bits [31:20]. funct3 selects the operation:
  - 000 ADDI, 100 XORI, 110 ORI, 111 ANDI
  - 001 SLLI (funct7 0000000)
  - 101 SRLI (funct7 0000000) or SRAI (funct7 0100000)
  - The shift amount is bits [24:20].
- R5: LW (opcode 0000011, funct3 010) and SW (opcode 0100011, funct3 010) move full words. The address is rs1 plus the sign-extended offset. The data word is selected by address bits [DAW+1:2]. SW raises `dm_we` and does not write a register. A store is visible to the next load.
- R6: Branches use opcode 1100011 with funct3 000 BEQ, 001 BNE, 100 BLT and 101 BGE. The outcome comes from the flags of rs1 minus rs2:
  - BEQ is taken on zero, BNE on not zero.
  - BLT is taken when negative XOR overflow is set, BGE when it is clear.
  - A taken branch moves the PC to PC plus the B-type offset; otherwise the PC advances by 4.
  - Branches write no register.
- R7: JAL (opcode 1101111) writes PC+4 to rd and moves the PC to PC plus the sign-extended J-type offset.
- R8: A JAL with zero offset and rd = x0 (word 0x0000006F) leaves the PC unchanged, so the core repeats it indefinitely and writes nothing.
- R9: Register x0 always reads as zero. An instruction naming x0 as destination leaves `rf_we` low.
- R10: Any other opcode or funct combination retires as a no-op: the PC advances by 4 and neither `rf_we` nor `dm_we` is raised.
- R11: The load stream accepts a word when `prog_valid` and `prog_ready` are both high, at instruction index `prog_addr[IAW+1:2]`. `prog_ready` equals `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| prog_valid | input | 1 | Load stream: word offered |
| prog_ready | output | 1 | Load stream: word accepted (only in reset) |
| prog_addr | input | 32 | Load stream: byte address of the instruction word |
| prog_data | input | 32 | Load stream: instruction word |
| ret_valid | output | 1 | Retire trace entry valid (every cycle out of reset) |
| ret_pc | output | 32 | Address of the retiring instruction |
| ret_insn | output | 32 | Retiring instruction word |
| rf_we | output | 1 | Register write this cycle |
| rf_waddr | output | 5 | Destination register index |
| rf_wdata | output | 32 | Value written to the register |
| dm_we | output | 1 | Data store write this cycle |
| dm_addr | output | 32 | Data byte address computed by the ALU |
| dm_wdata | output | 32 | Word written to the data store |

## Verification
The bench builds the core with its default sizes: 64 instruction words and 64 data words. At these sizes, byte address 0x100 aliases data word 0, so the stored factorial result and its reload exercise the index slice [DAW+1:2] rather than the full address. The program fills 48 of the 64 instruction slots, and the unused slots hold zero words that decode as no-ops. With these sizes, a multiply-by-addition factorial loop runs roughly a hundred cycles, followed by a straight-line section that reaches every supported operation, a signed-overflow BLT, a linking JAL, writes aimed at x0, two unsupported encodings, and the halt loop.

// File: rtl/rv_pkg.sv
package rv_pkg;
  localparam int XLEN = 32;

  localparam logic [6:0] OPC_REG    = 7'b0110011;
  localparam logic [6:0] OPC_IMM    = 7'b0010011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLL, ALU_SRL, ALU_SRA
  } alu_op_e;

  typedef enum logic [1:0] { WB_ALU, WB_MEM, WB_LINK } wb_sel_e;

  typedef struct packed {
    logic z;
    logic n;
    logic v;
    logic c;
  } alu_flags_t;

  typedef struct packed {
    logic            reg_we;
    logic            mem_we;
    logic            use_imm;
    logic            is_branch;
    logic            is_jal;
    alu_op_e         alu_op;
    wb_sel_e         wb_sel;
    logic [XLEN-1:0] imm;
  } ctrl_t;
endpackage

// File: rtl/rv_alu.sv
module rv_alu
  import rv_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e    op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output alu_flags_t   fl
);
  localparam int SHW = $clog2(W);

  logic         sub_m;
  logic [W-1:0] bx;
  logic [W:0]   sum;
  logic signed [W-1:0] sra_r;

  always_comb begin
    sub_m = (op == ALU_SUB);
    bx    = sub_m ? ~b : b;
    sum   = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, sub_m};
    sra_r = $signed(a) >>> b[SHW-1:0];
    unique case (op)
      ALU_ADD, ALU_SUB: y = sum[W-1:0];
      ALU_AND:          y = a & b;
      ALU_OR:           y = a | b;
      ALU_XOR:          y = a ^ b;
      ALU_SLL:          y = a << b[SHW-1:0];
      ALU_SRL:          y = a >> b[SHW-1:0];
      ALU_SRA:          y = sra_r;
      default:          y = '0;
    endcase
    fl.z = (y == '0);
    fl.n = y[W-1];
    fl.c = sum[W];
    fl.v = (a[W-1] == bx[W-1]) && (sum[W-1] != a[W-1]);
  end
endmodule

// File: rtl/rv_regfile.sv
module rv_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [$clog2(NREG)-1:0] ra1,
  input  logic [$clog2(NREG)-1:0] ra2,
  output logic [W-1:0]            rd1,
  output logic [W-1:0]            rd2,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] wa,
  input  logic [W-1:0]            wd
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NREG; k++) regs[k] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/rv_decode.sv
module rv_decode
  import rv_pkg::*;
(
  input  logic [31:0] insn,
  output ctrl_t       ctl
);
  logic [6:0]  opc;
  logic [2:0]  f3;
  logic [6:0]  f7;
  logic [31:0] imm_i, imm_s, imm_b, imm_j;

  assign opc   = insn[6:0];
  assign f3    = insn[14:12];
  assign f7    = insn[31:25];
  assign imm_i = {{20{insn[31]}}, insn[31:20]};
  assign imm_s = {{20{insn[31]}}, insn[31:25], insn[11:7]};
  assign imm_b = {{19{insn[31]}}, insn[31], insn[7], insn[30:25], insn[11:8], 1'b0};
  assign imm_j = {{11{insn[31]}}, insn[31], insn[19:12], insn[20], insn[30:21], 1'b0};

  always_comb begin
    ctl        = '0;
    ctl.alu_op = ALU_ADD;
    ctl.wb_sel = WB_ALU;
    case (opc)
      OPC_REG: begin
        ctl.reg_we = 1'b1;
        case ({f7, f3})
          {7'h00, 3'd0}: ctl.alu_op = ALU_ADD;
          {7'h20, 3'd0}: ctl.alu_op = ALU_SUB;
          {7'h00, 3'd1}: ctl.alu_op = ALU_SLL;
          {7'h00, 3'd5}: ctl.alu_op = ALU_SRL;
          {7'h20, 3'd5}: ctl.alu_op = ALU_SRA;
          {7'h00, 3'd4}: ctl.alu_op = ALU_XOR;
          {7'h00, 3'd6}: ctl.alu_op = ALU_OR;
          {7'h00, 3'd7}: ctl.alu_op = ALU_AND;
          default:       ctl.reg_we = 1'b0;
        endcase
      end
      OPC_IMM: begin
        ctl.reg_we  = 1'b1;
        ctl.use_imm = 1'b1;
        ctl.imm     = imm_i;
        case (f3)
          3'd0: ctl.alu_op = ALU_ADD;
          3'd4: ctl.alu_op = ALU_XOR;
          3'd6: ctl.alu_op = ALU_OR;
          3'd7: ctl.alu_op = ALU_AND;
          3'd1: if (f7 == 7'h00) ctl.alu_op = ALU_SLL; else ctl.reg_we = 1'b0;
          3'd5: if (f7 == 7'h00) ctl.alu_op = ALU_SRL;
                else if (f7 == 7'h20) ctl.alu_op = ALU_SRA;
                else ctl.reg_we = 1'b0;
          default: ctl.reg_we = 1'b0;
        endcase
      end
      OPC_LOAD: if (f3 == 3'd2) begin
        ctl.reg_we  = 1'b1;
        ctl.use_imm = 1'b1;
        ctl.imm     = imm_i;
        ctl.wb_sel  = WB_MEM;
      end
      OPC_STORE: if (f3 == 3'd2) begin
        ctl.mem_we  = 1'b1;
        ctl.use_imm = 1'b1;
        ctl.imm     = imm_s;
      end
      OPC_BRANCH: if (f3 == 3'd0 || f3 == 3'd1 || f3 == 3'd4 || f3 == 3'd5) begin
        ctl.is_branch = 1'b1;
        ctl.alu_op    = ALU_SUB;
        ctl.imm       = imm_b;
      end
      OPC_JAL: begin
        ctl.is_jal = 1'b1;
        ctl.reg_we = 1'b1;
        ctl.wb_sel = WB_LINK;
        ctl.imm    = imm_j;
      end
      default: ;
    endcase
    if (insn[11:7] == 5'd0) ctl.reg_we = 1'b0;
  end
endmodule

// File: rtl/rv_core.sv
module rv_core
  import rv_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        prog_valid,
  output logic        prog_ready,
  input  logic [31:0] prog_addr,
  input  logic [31:0] prog_data,
  output logic        ret_valid,
  output logic [31:0] ret_pc,
  output logic [31:0] ret_insn,
  output logic        rf_we,
  output logic [4:0]  rf_waddr,
  output logic [31:0] rf_wdata,
  output logic        dm_we,
  output logic [31:0] dm_addr,
  output logic [31:0] dm_wdata
);
  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);

  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];
  logic [XLEN-1:0] pc, pc_next, insn, rs1v, rs2v, alu_b, alu_y, mem_rd, wb_val;
  ctrl_t           ctl;
  alu_flags_t      fl;
  logic            cond, take;

  // program load stream, open only while reset is held
  assign prog_ready = rst;
  always_ff @(posedge clk) begin
    if (prog_valid && prog_ready) imem[prog_addr[IAW+1:2]] <= prog_data;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  assign insn = imem[pc[IAW+1:2]];

  rv_decode u_dec (.insn(insn), .ctl(ctl));

  rv_regfile #(.W(XLEN), .NREG(32)) u_rf (
    .clk(clk), .rst(rst),
    .ra1(insn[19:15]), .ra2(insn[24:20]),
    .rd1(rs1v), .rd2(rs2v),
    .we(rf_we), .wa(insn[11:7]), .wd(wb_val)
  );

  assign alu_b = ctl.use_imm ? ctl.imm : rs2v;

  rv_alu #(.W(XLEN)) u_alu (.op(ctl.alu_op), .a(rs1v), .b(alu_b), .y(alu_y), .fl(fl));

  // data store
  assign mem_rd = dmem[alu_y[DAW+1:2]];
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DMEM_WORDS; k++) dmem[k] <= '0;
    end else if (dm_we) begin
      dmem[alu_y[DAW+1:2]] <= rs2v;
    end
  end

  // branch resolution from the ALU flags
  always_comb begin
    case (insn[14:12])
      3'd0:    cond = fl.z;
      3'd1:    cond = !fl.z;
      3'd4:    cond = fl.n ^ fl.v;
      3'd5:    cond = !(fl.n ^ fl.v);
      default: cond = 1'b0;
    endcase
    take    = ctl.is_jal || (ctl.is_branch && cond);
    pc_next = take ? pc + ctl.imm : pc + 32'd4;
    unique case (ctl.wb_sel)
      WB_MEM:  wb_val = mem_rd;
      WB_LINK: wb_val = pc + 32'd4;
      default: wb_val = alu_y;
    endcase
  end

  assign ret_valid = !rst;
  assign ret_pc    = pc;
  assign ret_insn  = insn;
  assign rf_we     = ctl.reg_we && !rst;
  assign rf_waddr  = insn[11:7];
  assign rf_wdata  = wb_val;
  assign dm_we     = ctl.mem_we && !rst;
  assign dm_addr   = alu_y;
  assign dm_wdata  = rs2v;

  logic unused_bits;
  assign unused_bits = ^{fl.c, pc[1:0], prog_addr[1:0], prog_addr[31:IAW+2], pc[31:IAW+2]};
endmodule

// File: rtl/rv_core_checks.sv
module rv_core_checks (
  input logic        clk,
  input logic        rst,
  input logic        ret_valid,
  input logic [31:0] ret_pc,
  input logic [31:0] ret_insn,
  input logic        rf_we,
  input logic [4:0]  rf_waddr,
  input logic [31:0] rf_wdata,
  input logic        dm_we
);
  logic seq_insn;
  assign seq_insn = (ret_insn[6:0] != 7'b1100011) && (ret_insn[6:0] != 7'b1101111);

  assert_seq_step_R1: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && seq_insn) |=> (rst || ret_pc == $past(ret_pc) + 32'd4));

  assert_reset_pc_R2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ret_pc == 32'd0));

  assert_store_no_regwrite_R5: assert property (@(posedge clk) disable iff (rst)
    dm_we |-> !rf_we);

  assert_link_value_R7: assert property (@(posedge clk) disable iff (rst)
    (ret_insn[6:0] == 7'b1101111 && ret_insn[11:7] != 5'd0) |-> (rf_we && rf_wdata == ret_pc + 32'd4));

  assert_halt_spin_R8: assert property (@(posedge clk) disable iff (rst)
    (ret_insn == 32'h0000006F) |=> (rst || (ret_pc == $past(ret_pc) && !rf_we && !dm_we)));

  assert_no_x0_write_R9: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (rf_waddr != 5'd0));
endmodule

bind rv_core rv_core_checks u_checks (
  .clk(clk), .rst(rst), .ret_valid(ret_valid), .ret_pc(ret_pc), .ret_insn(ret_insn),
  .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .dm_we(dm_we)
);

// File: tb/tb_rv_core.sv
module tb_rv_core;
  localparam int CLK_PERIOD = 10;
  localparam int NCYC       = 400;
  localparam int NWORDS     = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        prog_valid = 1'b0;
  logic        prog_ready;
  logic [31:0] prog_addr = '0;
  logic [31:0] prog_data = '0;
  logic        ret_valid, rf_we, dm_we;
  logic [31:0] ret_pc, ret_insn, rf_wdata, dm_addr, dm_wdata;
  logic [4:0]  rf_waddr;

  rv_core dut (
    .clk(clk), .rst(rst), .prog_valid(prog_valid), .prog_ready(prog_ready),
    .prog_addr(prog_addr), .prog_data(prog_data), .ret_valid(ret_valid),
    .ret_pc(ret_pc), .ret_insn(ret_insn), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [31:0] pc;
    logic        rf_we;
    logic [4:0]  waddr;
    logic [31:0] wdata;
    logic        dm_we;
    logic [31:0] daddr;
    logic [31:0] dwdata;
  } exp_t;

  exp_t  q_exp [$];
  string q_tag [$];
  int    nchk = 0, nfail = 0;
  bit    done = 0;

  logic [31:0] img   [NWORDS];
  logic [31:0] iss_rf [32];
  logic [31:0] iss_dm [NWORDS];
  logic [31:0] iss_pc;

  function automatic logic [31:0] enc_r(input int f7, rs2, rs1, f3, rd);
    return {f7[6:0], rs2[4:0], rs1[4:0], f3[2:0], rd[4:0], 7'h33};
  endfunction
  function automatic logic [31:0] enc_i(input int op, imm, rs1, f3, rd);
    return {imm[11:0], rs1[4:0], f3[2:0], rd[4:0], op[6:0]};
  endfunction
  function automatic logic [31:0] enc_s(input int imm, rs2, rs1);
    return {imm[11:5], rs2[4:0], rs1[4:0], 3'd2, imm[4:0], 7'h23};
  endfunction
  function automatic logic [31:0] enc_b(input int f3, rs1, rs2, off);
    return {off[12], off[10:5], rs2[4:0], rs1[4:0], f3[2:0], off[4:1], off[11], 7'h63};
  endfunction
  function automatic logic [31:0] enc_j(input int rd, off);
    return {off[20], off[10:1], off[11], off[19:12], rd[4:0], 7'h6F};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // reference model: returns the requirement tag of the instruction it retires
  function automatic string iss_step(output exp_t e);
    logic [31:0] i, a, b, immi, imms, immb, immj, val, nxt, addr;
    logic        we, tk;
    string       tag;
    i    = img[iss_pc[7:2]];
    a    = iss_rf[i[19:15]];
    b    = iss_rf[i[24:20]];
    immi = {{20{i[31]}}, i[31:20]};
    imms = {{20{i[31]}}, i[31:25], i[11:7]};
    immb = {{19{i[31]}}, i[31], i[7], i[30:25], i[11:8], 1'b0};
    immj = {{11{i[31]}}, i[31], i[19:12], i[20], i[30:21], 1'b0};
    e = '0; e.pc = iss_pc; nxt = iss_pc + 4; we = 0; val = '0; tag = "R10"; tk = 0;
    case (i[6:0])
      7'h33: begin
        tag = "R3"; we = 1;
        case ({i[31:25], i[14:12]})
          {7'h00, 3'd0}: val = a + b;
          {7'h20, 3'd0}: val = a - b;
          {7'h00, 3'd1}: val = a << b[4:0];
          {7'h00, 3'd5}: val = a >> b[4:0];
          {7'h20, 3'd5}: val = $unsigned($signed(a) >>> b[4:0]);
          {7'h00, 3'd4}: val = a ^ b;
          {7'h00, 3'd6}: val = a | b;
          {7'h00, 3'd7}: val = a & b;
          default: begin we = 0; tag = "R10"; end
        endcase
      end
      7'h13: begin
        tag = "R4"; we = 1;
        case (i[14:12])
          3'd0: val = a + immi;
          3'd4: val = a ^ immi;
          3'd6: val = a | immi;
          3'd7: val = a & immi;
          3'd1: if (i[31:25] == 7'h00) val = a << i[24:20]; else begin we = 0; tag = "R10"; end
          3'd5: if (i[31:25] == 7'h00) val = a >> i[24:20];
                else if (i[31:25] == 7'h20) val = $unsigned($signed(a) >>> i[24:20]);
                else begin we = 0; tag = "R10"; end
          default: begin we = 0; tag = "R10"; end
        endcase
      end
      7'h03: if (i[14:12] == 3'd2) begin
        tag = "R5"; we = 1; addr = a + immi; val = iss_dm[addr[7:2]];
      end
      7'h23: if (i[14:12] == 3'd2) begin
        tag = "R5"; addr = a + imms;
        e.dm_we = 1; e.daddr = addr; e.dwdata = b; iss_dm[addr[7:2]] = b;
      end
      7'h63: begin
        tag = "R6";
        case (i[14:12])
          3'd0: tk = (a == b);
          3'd1: tk = (a != b);
          3'd4: tk = ($signed(a) <  $signed(b));
          3'd5: tk = ($signed(a) >= $signed(b));
          default: tag = "R10";
        endcase
        if (tk) nxt = iss_pc + immb;
      end
      7'h6F: begin
        tag = (i == 32'h0000006F) ? "R8" : "R7";
        we = 1; val = iss_pc + 4; nxt = iss_pc + immj;
      end
      default: ;
    endcase
    if (we && i[11:7] != 5'd0) begin
      iss_rf[i[11:7]] = val; e.rf_we = 1; e.waddr = i[11:7]; e.wdata = val;
    end else if (we && tag != "R8") begin
      tag = "R9";
    end
    iss_pc = nxt;
    return tag;
  endfunction

  task automatic push_next();
    exp_t  e;
    string t;
    t = iss_step(e);
    q_exp.push_back(e);
    q_tag.push_back(t);
  endtask

  task automatic build_program();
    for (int k = 0; k < NWORDS; k++) img[k] = 32'h0;
    img[0]  = enc_i(7'h13, 5, 0, 0, 5);
    img[1]  = enc_i(7'h13, 1, 0, 0, 6);
    img[2]  = enc_i(7'h13, 32'h100, 0, 0, 11);
    img[3]  = enc_b(0, 5, 0, 32'h2C);
    img[4]  = enc_i(7'h13, 0, 0, 0, 10);
    img[5]  = enc_i(7'h13, 0, 5, 0, 9);
    img[6]  = enc_b(0, 9, 0, 32'h10);
    img[7]  = enc_r(0, 6, 10, 0, 10);
    img[8]  = enc_i(7'h13, -1, 9, 0, 9);
    img[9]  = enc_j(0, -12);
    img[10] = enc_i(7'h13, 0, 10, 0, 6);
    img[11] = enc_i(7'h13, -1, 5, 0, 5);
    img[12] = enc_j(0, -36);
    img[13] = enc_i(7'h13, 0, 0, 0, 0);
    img[14] = enc_s(0, 6, 11);
    img[15] = enc_i(7'h03, 0, 11, 2, 7);
    img[16] = enc_r(7'h20, 7, 0, 0, 12);
    img[17] = enc_i(7'h13, 3, 0, 0, 14);
    img[18] = enc_r(7'h20, 14, 12, 5, 13);
    img[19] = enc_r(0, 14, 12, 5, 15);
    img[20] = enc_r(0, 14, 7, 1, 16);
    img[21] = enc_r(0, 12, 7, 4, 19);
    img[22] = enc_r(0, 14, 7, 6, 20);
    img[23] = enc_r(0, 12, 7, 7, 21);
    img[24] = enc_i(7'h13, 32'h402, 12, 5, 22);
    img[25] = enc_i(7'h13, 28, 12, 5, 23);
    img[26] = enc_i(7'h13, 4, 7, 1, 24);
    img[27] = enc_i(7'h13, -1, 7, 4, 25);
    img[28] = enc_i(7'h13, 32'h0F, 7, 6, 26);
    img[29] = enc_i(7'h13, 32'hF0, 12, 7, 27);
    img[30] = enc_i(7'h13, 1, 0, 0, 18);
    img[31] = enc_i(7'h13, 31, 18, 1, 17);
    img[32] = enc_b(4, 17, 18, 8);
    img[33] = enc_i(7'h13, 99, 0, 0, 28);
    img[34] = enc_b(5, 17, 18, 8);
    img[35] = enc_i(7'h13, 1, 0, 0, 28);
    img[36] = enc_b(1, 28, 18, 8);
    img[37] = enc_b(5, 18, 17, 8);
    img[38] = enc_i(7'h13, 77, 0, 0, 28);
    img[39] = enc_b(4, 18, 17, 8);
    img[40] = enc_j(1, 8);
    img[41] = enc_i(7'h13, 55, 0, 0, 28);
    img[42] = enc_r(0, 3, 1, 2, 29);
    img[43] = enc_i(7'h13, 7, 0, 0, 0);
    img[44] = enc_s(4, 28, 11);
    img[45] = enc_r(0, 18, 0, 0, 31);
    img[46] = enc_i(7'h03, 0, 11, 0, 29);
    img[47] = enc_j(0, 0);
  endtask

  // directed checks tied to specific program points
  task automatic directed(input exp_t e);
    case (e.pc)
      32'h38: chk(dm_we && dm_wdata == 32'd120 && dm_addr == 32'h100, "R5", "factorial store", dm_wdata, 32'd120);
      32'h3C: chk(rf_we && rf_waddr == 5'd7 && rf_wdata == 32'd120, "R5", "reload", rf_wdata, 32'd120);
      32'h60: chk(rf_wdata == 32'hFFFFFFE2, "R4", "srai", rf_wdata, 32'hFFFFFFE2);
      32'h80: chk(1'b1, "R6", "blt overflow seen", ret_pc, 32'h80);
      32'h88: chk(ret_pc == 32'h88, "R6", "blt signed overflow taken", ret_pc, 32'h88);
      32'hA0: chk(rf_we && rf_wdata == 32'hA4, "R7", "jal link", rf_wdata, 32'hA4);
      32'hA8: chk(!rf_we && !dm_we, "R10", "slt treated as no-op", {30'd0, rf_we, dm_we}, 32'd0);
      32'hAC: chk(!rf_we, "R9", "write to x0 suppressed", {31'd0, rf_we}, 32'd0);
      32'hB4: chk(rf_wdata == 32'd1, "R9", "x0 reads zero", rf_wdata, 32'd1);
      32'hB8: chk(!rf_we, "R10", "byte load no-op", {31'd0, rf_we}, 32'd0);
      default: ;
    endcase
  endtask

  task automatic monitor();
    logic [31:0] last_pc = '0;
    for (int c = 0; c < NCYC; c++) begin
      exp_t  e;
      string t;
      if (c > 0) @(negedge clk);
      #1;
      if (q_exp.size() == 0) begin
        chk(1'b0, "R1", "scoreboard underflow", 32'd0, 32'd1);
        continue;
      end
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      if (c == 0) chk(ret_pc == 32'h0, "R2", "first pc after reset", ret_pc, 32'h0);
      chk(ret_valid, "R1", "retire valid", {31'd0, ret_valid}, 32'd1);
      chk(ret_pc == e.pc, t, "pc", ret_pc, e.pc);
      chk(rf_we == e.rf_we && (!e.rf_we || (rf_waddr == e.waddr && rf_wdata == e.wdata)),
          t, "reg write", rf_wdata, e.wdata);
      chk(dm_we == e.dm_we && (!e.dm_we || (dm_addr == e.daddr && dm_wdata == e.dwdata)),
          t, "mem write", dm_wdata, e.dwdata);
      directed(e);
      last_pc = ret_pc;
    end
    chk(last_pc == 32'hBC && ret_insn == 32'h0000006F, "R8", "halted at spin", last_pc, 32'hBC);
  endtask

  task automatic driver();
    for (int c = 1; c < NCYC; c++) begin
      @(posedge clk);
      #1;
      push_next();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", nchk, NCYC);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    build_program();
    for (int k = 0; k < 32; k++) iss_rf[k] = '0;
    for (int k = 0; k < NWORDS; k++) iss_dm[k] = '0;
    iss_pc = '0;
    repeat (2) @(negedge clk);
    chk(!ret_valid && !rf_we && !dm_we, "R2", "idle in reset",
        {29'd0, ret_valid, rf_we, dm_we}, 32'd0);
    chk(prog_ready, "R11", "load ready in reset", {31'd0, prog_ready}, 32'd1);
    for (int k = 0; k < NWORDS; k++) begin
      prog_valid = 1'b1;
      prog_addr  = k * 4;
      prog_data  = img[k];
      @(negedge clk);
    end
    prog_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    push_next();
    #1;
    chk(!prog_ready, "R11", "load closed after reset", {31'd0, prog_ready}, 32'd0);
    // a load word offered while running must not be written (R11)
    prog_valid = 1'b1; prog_addr = 32'hBC; prog_data = enc_i(7'h13, 1, 0, 0, 3);
    fork
      driver();
      monitor();
    join
    prog_valid = 1'b0;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule